// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

The block gathers interrupt requests on eight numbered lines, keeps them in a pending register and raises one summary output while any pending line is not masked. Software sets it up through a byte-wide write port with one address bit. A short setup sequence of two to four words selects level or edge detection and chooses single or cascaded operation. In cascaded operation it also records either which inputs carry downstream controllers or the controller's own 3-bit identity.

One instance is strapped as the upstream (master) controller and any number as downstream (slave) controllers. A slave that accepts an unmasked request pulses a forwarding output that carries its identity. Its summary output can also be wired to one of the master's cascade inputs. The master accepts cascade inputs only on lines that its setup marked as having a downstream controller. In a typical system a periodic alarm drives line 0 of a slave.

Top module: `cascade_pic`

## Requirements
- R1: After reset the mask is all ones, nothing is pending, `ready` is 0 and `int_out` is 0. Because of the mask, a request made before setup is dropped.
- R2: A write with `wr_a0`=0 and data bit 4 set starts a new setup sequence, drops `ready` and clears all pending requests. A write with `wr_a0`=0 and bit 4 clear has no effect.
- R3: If bit 1 of the first word is set (single mode), the sequence skips the third word and clears both the downstream-line map and the identity.
- R4: On a master in cascade mode, the third word is stored as a line map. A cascade input is accepted only on a line whose map bit is 1.
- R5: On a slave in cascade mode, only bits 2:0 of the third word are kept, as the identity.
- R6: A fourth word is expected only if bit 0 of the first word was set. `ready` rises in the cycle after the last word of the sequence is written.
- R7: Once `ready` is 1, each write with `wr_a0`=1 loads the mask register. Mask bit n set means line n is masked.
- R8: A request on a masked line is neither latched nor forwarded. Clearing the mask later does not bring it back.
- R9: A numbered request with `req_line` greater than 7 pulses `line_err` for one cycle, one cycle later, and nothing is latched.
- R10: `int_out` is 1 whenever some pending bit is 1 and its mask bit is 0. It follows a request or a mask write one cycle later.
- R11: A slave that accepts a request pulses `fwd_valid` for one cycle, one cycle later, with `fwd_line` equal to its identity.
- R12: Bit 3 of the first word selects the detection mode. With bit 3 = 0 (edge), requests stay pending and a cascade input is taken on its rising edge. With bit 3 = 1 (level), the pending register holds only the requests present in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | Strap: 1 = master, 0 = slave |
| wr_en | input | 1 | Register write strobe |
| wr_a0 | input | 1 | Register address bit |
| wr_data | input | 8 | Write data |
| req_valid | input | 1 | Numbered request strobe |
| req_line | input | 4 | Line number of the request |
| cas_in | input | 8 | Cascade inputs from slave summary outputs |
| int_out | output | 1 | Unmasked pending summary |
| fwd_valid | output | 1 | Slave forwarding pulse |
| fwd_line | output | 3 | Master line targeted by the forwarding |
| line_err | output | 1 | Out-of-range request flag |
| ready | output | 1 | Setup sequence complete |

## Verification
Every result is registered once. Pending state, `line_err`, `fwd_valid` and the sequencer state all change at the clock edge that samples the stimulus. `int_out` and `ready` are decoded from that state, so each of them is due exactly one cycle after its cause. The bench drives inputs on the falling edge. It advances a behavioural model on the rising edge and compares all outputs 3 ns after that edge. Directed checks read the outputs at the falling edge that follows each stimulus cycle, and they add extra idle cycles where a result must persist or decay.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NLINES = 8;
    localparam int IDW    = $clog2(NLINES);
    localparam int LINEW  = IDW + 1;

    // first-word field positions
    localparam int W1_START_BIT  = 4;
    localparam int W1_LEVEL_BIT  = 3;
    localparam int W1_SINGLE_BIT = 1;
    localparam int W1_NEED4_BIT  = 0;

    typedef enum logic [2:0] {
        SQ_WAIT1,
        SQ_WORD2,
        SQ_WORD3,
        SQ_WORD4,
        SQ_READY
    } seq_e;

    typedef struct packed {
        seq_e              st;
        logic              level;
        logic              single;
        logic              need4;
        logic [NLINES-1:0] casmap;
        logic [IDW-1:0]    id;
        logic [NLINES-1:0] mask;
    } seq_t;

    typedef struct packed {
        logic [NLINES-1:0] irr;
        logic [NLINES-1:0] cas_prev;
        logic              fwd;
        logic              err;
    } req_t;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              wr_en,
    input  logic              wr_a0,
    input  logic [NLINES-1:0] wr_data,
    output logic              init_start,
    output logic              level_mode,
    output logic [NLINES-1:0] casmap,
    output logic [IDW-1:0]    slave_id,
    output logic [NLINES-1:0] mask,
    output logic              ready
);
    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        init_start = 1'b0;
        if (wr_en) begin
            if (!wr_a0) begin
                if (wr_data[W1_START_BIT]) begin
                    init_start   = 1'b1;
                    seq_d.st     = SQ_WORD2;
                    seq_d.level  = wr_data[W1_LEVEL_BIT];
                    seq_d.single = wr_data[W1_SINGLE_BIT];
                    seq_d.need4  = wr_data[W1_NEED4_BIT];
                    if (wr_data[W1_SINGLE_BIT]) begin
                        seq_d.casmap = '0;
                        seq_d.id     = '0;
                    end
                end
            end else begin
                unique case (seq_q.st)
                    SQ_WORD2: begin
                        if (seq_q.single)
                            seq_d.st = seq_q.need4 ? SQ_WORD4 : SQ_READY;
                        else
                            seq_d.st = SQ_WORD3;
                    end
                    SQ_WORD3: begin
                        if (cfg_master) seq_d.casmap = wr_data;
                        else            seq_d.id     = wr_data[IDW-1:0];
                        seq_d.st = seq_q.need4 ? SQ_WORD4 : SQ_READY;
                    end
                    SQ_WORD4: seq_d.st   = SQ_READY;
                    SQ_READY: seq_d.mask = wr_data;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.st     <= SQ_WAIT1;
            seq_q.mask   <= '1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign level_mode = seq_q.level;
    assign casmap     = seq_q.casmap;
    assign slave_id   = seq_q.id;
    assign mask       = seq_q.mask;
    assign ready      = (seq_q.st == SQ_READY);

    AST_MASK_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_q.mask) |-> $past(seq_q.st == SQ_READY && wr_en && wr_a0)); // R7
    AST_SINGLE_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_a0 && wr_data[W1_START_BIT] && wr_data[W1_SINGLE_BIT])
        |=> (seq_q.casmap == '0 && seq_q.id == '0)); // R3
    AST_SINGLE_SKIPS_WORD3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_a0 && seq_q.st == SQ_WORD2 && seq_q.single)
        |=> (seq_q.st != SQ_WORD3)); // R3
    AST_WORD4_ONLY_IF_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_WORD4) |-> seq_q.need4); // R6
endmodule

// File: rtl/pic_req_unit.sv
module pic_req_unit
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              clear,
    input  logic              level_mode,
    input  logic [NLINES-1:0] casmap,
    input  logic [NLINES-1:0] mask,
    input  logic [IDW-1:0]    slave_id,
    input  logic              req_valid,
    input  logic [LINEW-1:0]  req_line,
    input  logic [NLINES-1:0] cas_in,
    output logic              int_out,
    output logic              fwd_valid,
    output logic [IDW-1:0]    fwd_line,
    output logic              line_err
);
    req_t req_d, req_q;
    logic [NLINES-1:0] hit, cas_new, cas_hit, accept;
    logic              bad;

    always_comb begin
        req_d   = req_q;
        hit     = '0;
        bad     = req_valid && (req_line >= LINEW'(NLINES));
        if (req_valid && !bad)
            hit[req_line[IDW-1:0]] = 1'b1;
        cas_new = level_mode ? cas_in : (cas_in & ~req_q.cas_prev);
        cas_hit = cfg_master ? (cas_new & casmap) : '0;
        accept  = (hit | cas_hit) & ~mask;
        if (clear)           req_d.irr = '0;
        else if (level_mode) req_d.irr = accept;
        else                 req_d.irr = req_q.irr | accept;
        req_d.cas_prev = cas_in;
        req_d.fwd      = !cfg_master && (|accept);
        req_d.err      = bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign int_out   = |(req_q.irr & ~mask);
    assign fwd_valid = req_q.fwd;
    assign fwd_line  = slave_id;
    assign line_err  = req_q.err;

    AST_MASKED_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master && req_valid && req_line < LINEW'(NLINES)
         && mask[req_line[IDW-1:0]]) |=> !fwd_valid); // R8
    AST_FWD_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(req_valid && !cfg_master)); // R11
    AST_BAD_LINE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |-> !fwd_valid); // R9
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !clear) |=> ((req_q.irr & $past(req_q.irr)) == $past(req_q.irr))); // R12
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              wr_en,
    input  logic              wr_a0,
    input  logic [NLINES-1:0] wr_data,
    input  logic              req_valid,
    input  logic [LINEW-1:0]  req_line,
    input  logic [NLINES-1:0] cas_in,
    output logic              int_out,
    output logic              fwd_valid,
    output logic [IDW-1:0]    fwd_line,
    output logic              line_err,
    output logic              ready
);
    logic              init_start, level_mode;
    logic [NLINES-1:0] casmap, mask;
    logic [IDW-1:0]    slave_id;

    pic_init_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_master (cfg_master),
        .wr_en      (wr_en),
        .wr_a0      (wr_a0),
        .wr_data    (wr_data),
        .init_start (init_start),
        .level_mode (level_mode),
        .casmap     (casmap),
        .slave_id   (slave_id),
        .mask       (mask),
        .ready      (ready)
    );

    pic_req_unit u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_master (cfg_master),
        .clear      (init_start),
        .level_mode (level_mode),
        .casmap     (casmap),
        .mask       (mask),
        .slave_id   (slave_id),
        .req_valid  (req_valid),
        .req_line   (req_line),
        .cas_in     (cas_in),
        .int_out    (int_out),
        .fwd_valid  (fwd_valid),
        .fwd_line   (fwd_line),
        .line_err   (line_err)
    );

    AST_RESTART_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_a0 && wr_data[W1_START_BIT]) |=> !ready); // R2
    AST_RESTART_CLEARS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_a0 && wr_data[W1_START_BIT]) |=> !int_out); // R10
endmodule

// File: tb/cascade_pic_test.sv
module cascade_pic_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1;
    logic       wr_en = 1'b0, wr_a0 = 1'b0;
    logic [7:0] wr_data = '0;
    logic       req_valid = 1'b0;
    logic [3:0] req_line = '0;
    logic [7:0] cas_in = '0;
    logic       int_out, fwd_valid, line_err, ready;
    logic [2:0] fwd_line;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cascade_pic uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
        .wr_en(wr_en), .wr_a0(wr_a0), .wr_data(wr_data),
        .req_valid(req_valid), .req_line(req_line), .cas_in(cas_in),
        .int_out(int_out), .fwd_valid(fwd_valid), .fwd_line(fwd_line),
        .line_err(line_err), .ready(ready)
    );

    // behavioural reference
    int         m_phase;   // 1 wait first word, 2..4 expecting word n, 5 done
    bit         m_level, m_single, m_four;
    bit [7:0]   m_map, m_imr, m_pend, m_prev;
    bit [2:0]   m_id;
    bit         m_fwd, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 1; m_level = 0; m_single = 0; m_four = 0;
            m_map = 0; m_imr = 8'hFF; m_pend = 0; m_prev = 0; m_id = 0;
            m_fwd = 0; m_err = 0;
        end else begin
            bit       oob, restart;
            bit [7:0] want, casr, take;
            oob  = req_valid && (req_line > 4'd7);
            want = (req_valid && !oob) ? (8'd1 << req_line[2:0]) : 8'd0;
            casr = m_level ? cas_in : (cas_in & ~m_prev);
            if (!cfg_master) casr = 0;
            take = (want | (casr & m_map)) & ~m_imr;
            restart = wr_en && !wr_a0 && wr_data[4];
            if (restart) m_pend = 0;
            else if (m_level) m_pend = take;
            else m_pend = m_pend | take;
            m_fwd  = !cfg_master && (take != 0);
            m_err  = oob;
            m_prev = cas_in;
            if (wr_en && restart) begin
                m_phase = 2; m_level = wr_data[3]; m_single = wr_data[1]; m_four = wr_data[0];
                if (m_single) begin m_map = 0; m_id = 0; end
            end else if (wr_en && wr_a0) begin
                if (m_phase == 2) m_phase = m_single ? (m_four ? 4 : 5) : 3;
                else if (m_phase == 3) begin
                    if (cfg_master) m_map = wr_data; else m_id = wr_data[2:0];
                    m_phase = m_four ? 4 : 5;
                end else if (m_phase == 4) m_phase = 5;
                else if (m_phase == 5) m_imr = wr_data;
            end
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, 3 ns after the rising edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            cmp("R10 int_out model", int'(int_out), int'((m_pend & ~m_imr) != 0));
            cmp("R6 ready model", int'(ready), int'(m_phase == 5));
            cmp("R9 line_err model", int'(line_err), int'(m_err));
            cmp("R11 fwd_valid model", int'(fwd_valid), int'(m_fwd));
            if (fwd_valid) cmp("R5 fwd_line model", int'(fwd_line), int'(m_id));
        end
    end

    task automatic wr(input bit a0, input bit [7:0] d);
        @(negedge clk); wr_en = 1; wr_a0 = a0; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rq(input bit [3:0] ln);
        @(negedge clk); req_valid = 1; req_line = ln;
        @(negedge clk); req_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input bit master);
        @(negedge clk); rst_n = 0; cfg_master = master; cas_in = 0;
        idle(3); rst_n = 1;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // master
        do_reset(1'b1);
        cmp("R1 int_out after reset", int'(int_out), 0);
        cmp("R1 ready after reset", int'(ready), 0);
        rq(4'd2);
        cmp("R1 request before setup dropped", int'(int_out), 0);

        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04);
        cmp("R6 waits for fourth word", int'(ready), 0);
        wr(1, 8'h01);
        cmp("R6 ready after fourth word", int'(ready), 1);
        wr(1, 8'h00);
        cmp("R1 early request not revived", int'(int_out), 0);

        @(negedge clk); cas_in[2] = 1;
        @(negedge clk);
        cmp("R4 mapped cascade line taken", int'(int_out), 1);
        idle(2);
        cmp("R12 edge request stays pending", int'(int_out), 1);
        cas_in = 0;

        wr(0, 8'h08);
        cmp("R2 first-word write without start ignored", int'(ready), 1);
        cmp("R2 pending kept", int'(int_out), 1);

        wr(0, 8'h11);
        cmp("R2 restart drops ready", int'(ready), 0);
        cmp("R2 restart clears pending", int'(int_out), 0);
        wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01); wr(1, 8'h00);
        @(negedge clk); cas_in[5] = 1;
        idle(2);
        cmp("R4 unmapped cascade line ignored", int'(int_out), 0);
        cas_in = 0;

        rq(4'd9);
        cmp("R9 out-of-range flagged", int'(line_err), 1);
        cmp("R9 out-of-range not latched", int'(int_out), 0);
        idle(1);
        cmp("R9 flag lasts one cycle", int'(line_err), 0);

        wr(1, 8'h08); rq(4'd3);
        cmp("R8 masked request dropped", int'(int_out), 0);
        wr(1, 8'h00); idle(1);
        cmp("R8 unmask does not revive", int'(int_out), 0);

        rq(4'd6);
        cmp("R10 unmasked request raises int_out", int'(int_out), 1);
        wr(1, 8'h40);
        cmp("R7 R10 mask hides pending", int'(int_out), 0);
        wr(1, 8'h00);
        cmp("R10 unmask shows pending", int'(int_out), 1);

        wr(0, 8'h1A); wr(1, 8'h20);
        cmp("R3 single mode skips third word", int'(ready), 1);
        wr(1, 8'h00);
        @(negedge clk); cas_in[2] = 1;
        idle(2);
        cmp("R3 single mode clears line map", int'(int_out), 0);
        cas_in = 0;
        rq(4'd1);
        cmp("R12 level request visible", int'(int_out), 1);
        idle(1);
        cmp("R12 level request decays", int'(int_out), 0);

        // slave
        do_reset(1'b0);
        wr(0, 8'h11); wr(1, 8'h70); wr(1, 8'hFD); wr(1, 8'h01); wr(1, 8'h00);
        rq(4'd0);
        cmp("R11 slave forwards", int'(fwd_valid), 1);
        cmp("R5 identity from low bits", int'(fwd_line), 5);
        idle(1);
        cmp("R11 forward is one pulse", int'(fwd_valid), 0);
        wr(1, 8'h01); rq(4'd0);
        cmp("R8 masked slave request not forwarded", int'(fwd_valid), 0);

        wr(0, 8'h13); wr(1, 8'h70); wr(1, 8'h01);
        cmp("R6 single with fourth word ready", int'(ready), 1);
        wr(1, 8'h00); rq(4'd4);
        cmp("R3 slave identity cleared", int'(fwd_line), 0);
        cmp("R11 forward after re-setup", int'(fwd_valid), 1);

        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule